// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the time at which chosen transitions happen on a set of input pins. Each channel watches one pin. It takes the value of a shared free-running timer bus at the moment a qualifying transition is accepted, and it pushes that value into a small first-in first-out store that belongs to the channel. The timer itself is outside the block and arrives as an input bus.

Each pin passes through a two-flop synchroniser. A new level is accepted only after it has been seen on two consecutive rising clock edges, so single-cycle glitches are dropped. A per-channel edge selector decides whether accepted rising transitions, falling transitions, both or none produce a capture.

A status word reports how full each store is. Software can overwrite the fill counts, for example to flush a channel. Each store's oldest entry is always visible on a read port, and a pop strobe removes it. Every capture raises a sticky per-channel flag, which is cleared by writing one. The flags are combined with a mask into a single registered interrupt line.

Top module: `capture_unit`

## Requirements
- R1: With a channel's 2-bit edge selector at 01, only accepted low-to-high transitions of its pin cause a capture.
- R2: With the selector at 10, only accepted high-to-low transitions cause a capture.
- R3: With the selector at 11, every accepted transition causes a capture.
- R4: With the selector at 00, no capture happens on that channel; its fill count and its head entry stay unchanged.
- R5: A pin level first sampled at rising edge n is written to the store at edge n+3, with the timer value present at that edge. A level that holds for only one cycle is never accepted.
- R6: The read port shows the oldest entry. A one-cycle pop removes it and lowers the count by one. A pop on an empty store has no effect, and the count never exceeds the depth.
- R7: A capture into a full store drops the oldest entry and keeps the new value, so the count stays at the depth.
- R8: The status word holds channel k's fill count in bits [9+2k:8+2k], coded 00 empty, 01 one entry, 10 two entries. Bits [7:0] read as zero. A status write loads each count from bits [2k+1:2k] of the write data, a value of 11 is taken as 10, and the write wins over a capture or pop in the same cycle.
- R9: A channel's flag is set by every capture on that channel and is cleared by a one-cycle pulse on its clear bit; a capture in the same cycle wins over the clear.
- R10: The interrupt line at edge n+1 equals the OR over channels of flag AND mask as they stood after edge n.
- R11: After reset, all fill counts, all flags and the interrupt line are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | TW | Shared timer value to timestamp with |
| cap_pin | input | NCH | Asynchronous capture pins, one per channel |
| edge_cfg | input | 2*NCH | Edge selector per channel, bits [2k+1:2k] for channel k |
| irq_mask | input | NCH | Per-channel interrupt enable |
| irq_clr | input | NCH | Write-one-to-clear pulses for the flags |
| rd_pop | input | NCH | Pop strobe per channel |
| rd_data | output | NCH*TW | Oldest entry of each channel, bits [TW*k+TW-1:TW*k] |
| stat_wr | input | 1 | Load the fill counts from stat_wdata |
| stat_wdata | input | NCH*clog2(DEPTH+1) | New fill counts, the write-only lower byte |
| fifo_stat | output | STW | Status word, fill counts in the upper half |
| irq_flag | output | NCH | Sticky capture flags |
| irq_out | output | 1 | Masked, ORed, registered interrupt |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit timer and two-deep stores. At these values every status code from empty to full appears, and the overwrite path for a full store is reachable after only three captures. With three channels, the rising, falling, both and disabled selectors can each be shown in a single pass without one channel's events hiding another's. The exact three-edge latency and the rejection of a one-cycle pulse are pinned by sampling the counts at the edge just before and just after the expected write.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cap_qualify.sv
module cap_qualify
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       evt
);
  logic s1, s2, s3, lvl;
  logic accept, rise, fall;
  edge_sel_e sel;

  assign sel    = edge_sel_e'(mode);
  assign accept = (s2 == s3) && (s2 != lvl);
  assign rise   = accept & s2;
  assign fall   = accept & ~s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      lvl <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
      if (accept) lvl <= s2;
    end
  end

  always_comb begin
    case (sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = accept;
      default:   evt = 1'b0;
    endcase
  end

  // R5
  hold_two_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> ($past(s2) == $past(s3)));

  // R5
  evt_level_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> (lvl != $past(lvl)));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [DW-1:0]   wdata,
  input  logic            pop,
  input  logic            set_cnt,
  input  logic [CNTW-1:0] cnt_in,
  output logic [CNTW-1:0] cnt,
  output logic [DW-1:0]   head
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [CNTW-1:0] count;
  logic            full, pop_ok, shift;
  logic [CNTW-1:0] widx;

  assign full   = (count == FULL_CNT);
  assign pop_ok = pop && (count != '0);
  assign shift  = pop_ok || (push && full);
  assign widx   = shift ? count - 1'b1 : count;

  // storage: no reset so it can map onto distributed or block memory
  always_ff @(posedge clk) begin
    if (!rst && !set_cnt) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (widx == CNTW'(i)))
          mem[i] <= wdata;
        else if (shift && (i < DEPTH - 1))
          mem[i] <= mem[(i + 1) % DEPTH];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (set_cnt) begin
      count <= (cnt_in > FULL_CNT) ? FULL_CNT : cnt_in;
    end else if (push && !pop_ok && !full) begin
      count <= count + 1'b1;
    end else if (pop_ok && !push) begin
      count <= count - 1'b1;
    end
  end

  assign cnt  = count;
  assign head = mem[0];

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R6
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !set_cnt && (count != '0)) |=> (count == $past(count) - 1'b1));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !set_cnt && (count == '0)) |=> (count == '0));

  // R8
  set_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    set_cnt |=> (count == (($past(cnt_in) > FULL_CNT) ? FULL_CNT : $past(cnt_in))));

  generate
    if (DEPTH > 1) begin : g_drop
      // R7
      full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !set_cnt && full) |=> ((count == FULL_CNT) && (mem[0] == $past(mem[1]))));
    end
  endgenerate
endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int NCH   = 3,
  parameter int TW    = 16,
  parameter int DEPTH = 2,
  parameter int STW   = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [TW-1:0]                     timer_val,
  input  logic [NCH-1:0]                    cap_pin,
  input  logic [2*NCH-1:0]                  edge_cfg,
  input  logic [NCH-1:0]                    irq_mask,
  input  logic [NCH-1:0]                    irq_clr,
  input  logic [NCH-1:0]                    rd_pop,
  output logic [NCH*TW-1:0]                 rd_data,
  input  logic                              stat_wr,
  input  logic [NCH*$clog2(DEPTH+1)-1:0]    stat_wdata,
  output logic [STW-1:0]                    fifo_stat,
  output logic [NCH-1:0]                    irq_flag,
  output logic                              irq_out
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int HALF = STW / 2;

  logic [NCH-1:0]  push_vec;
  logic [CNTW-1:0] cnt_v [NCH];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      cap_qualify u_qual (
        .clk  (clk),
        .rst  (rst),
        .pin  (cap_pin[g]),
        .mode (edge_cfg[2*g +: 2]),
        .evt  (push_vec[g])
      );

      cap_fifo #(
        .DW    (TW),
        .DEPTH (DEPTH),
        .CNTW  (CNTW)
      ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push_vec[g]),
        .wdata   (timer_val),
        .pop     (rd_pop[g]),
        .set_cnt (stat_wr),
        .cnt_in  (stat_wdata[CNTW*g +: CNTW]),
        .cnt     (cnt_v[g]),
        .head    (rd_data[TW*g +: TW])
      );
    end
  endgenerate

  always_comb begin
    fifo_stat = '0;
    for (int k = 0; k < NCH; k++)
      fifo_stat[HALF + CNTW*k +: CNTW] = cnt_v[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= '0;
      irq_out  <= 1'b0;
    end else begin
      irq_flag <= (irq_flag & ~irq_clr) | push_vec;
      irq_out  <= |(irq_flag & irq_mask);
    end
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|push_vec) |=> ((irq_flag & $past(push_vec)) == $past(push_vec)));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|(irq_clr & ~push_vec)) |=> ((irq_flag & $past(irq_clr & ~push_vec)) == '0));

  // R10
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|($past(irq_flag) & $past(irq_mask))));
endmodule

// File: tb/tb_capture_unit.sv
module tb_capture_unit;
  localparam int NCH = 3;
  localparam int TW  = 16;
  localparam int NV  = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TW-1:0]   timer_val = '0;
  logic [NCH-1:0]  cap_pin = '0;
  logic [2*NCH-1:0] edge_cfg = '0;
  logic [NCH-1:0]  irq_mask = '0;
  logic [NCH-1:0]  irq_clr = '0;
  logic [NCH-1:0]  rd_pop = '0;
  logic [NCH*TW-1:0] rd_data;
  logic            stat_wr = 1'b0;
  logic [2*NCH-1:0] stat_wdata = '0;
  logic [15:0]     fifo_stat;
  logic [NCH-1:0]  irq_flag;
  logic            irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  capture_unit dut (
    .clk(clk), .rst(rst), .timer_val(timer_val), .cap_pin(cap_pin),
    .edge_cfg(edge_cfg), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .rd_pop(rd_pop), .rd_data(rd_data), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .fifo_stat(fifo_stat), .irq_flag(irq_flag),
    .irq_out(irq_out)
  );

  // {ch, mode, level, timer, check_head, exp_count, exp_head}
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 2'b01, 1'b1, 16'h1111, 1'b1, 2'd1, 16'h1111},
    {2'd0, 2'b01, 1'b0, 16'h2222, 1'b1, 2'd1, 16'h1111},
    {2'd0, 2'b01, 1'b1, 16'h3333, 1'b1, 2'd2, 16'h1111},
    {2'd0, 2'b01, 1'b0, 16'h4444, 1'b1, 2'd2, 16'h1111},
    {2'd0, 2'b01, 1'b1, 16'h5555, 1'b1, 2'd2, 16'h3333},
    {2'd1, 2'b10, 1'b1, 16'h0A01, 1'b0, 2'd0, 16'h0000},
    {2'd1, 2'b10, 1'b0, 16'h0A02, 1'b1, 2'd1, 16'h0A02},
    {2'd2, 2'b11, 1'b1, 16'h0B01, 1'b1, 2'd1, 16'h0B01},
    {2'd2, 2'b11, 1'b0, 16'h0B02, 1'b1, 2'd2, 16'h0B01},
    {2'd2, 2'b00, 1'b1, 16'h0B03, 1'b1, 2'd2, 16'h0B01},
    {2'd2, 2'b00, 1'b0, 16'h0B04, 1'b1, 2'd2, 16'h0B01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] cnt_of(input int ch);
    return fifo_stat[8 + 2*ch +: 2];
  endfunction

  task automatic pop_one(input int ch);
    rd_pop[ch] = 1'b1;
    nedge(1);
    rd_pop[ch] = 1'b0;
    nedge(1);
  endtask

  task automatic stat_write(input logic [5:0] v);
    stat_wdata = v;
    stat_wr = 1'b1;
    nedge(1);
    stat_wr = 1'b0;
    nedge(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    nedge(3);
    rst = 1'b0;
    nedge(1);
    // R11 reset state
    check("R11 status", 32'(fifo_stat), 32'h0);
    check("R11 flags", 32'(irq_flag), 32'h0);
    check("R11 irq", 32'(irq_out), 32'h0);

    // table walk: R1 R2 R3 R4 R7 R8
    for (int r = 0; r < NV; r++) begin
      automatic int ch = int'(VEC[r][39:38]);
      edge_cfg[2*ch +: 2] = VEC[r][37:36];
      timer_val = VEC[r][34:19];
      nedge(1);
      cap_pin[ch] = VEC[r][35];
      nedge(6);
      check($sformatf("R1 R2 R3 R4 R7 R8 row %0d count", r),
            32'(cnt_of(ch)), 32'(VEC[r][17:16]));
      if (VEC[r][18])
        check($sformatf("R1 R2 R3 R4 R7 row %0d head", r),
              32'(rd_data[TW*ch +: TW]), 32'(VEC[r][15:0]));
    end

    // R9 flags set by captures on all three channels
    check("R9 flags set", 32'(irq_flag), 32'h7);
    // R10 masked interrupt
    irq_mask = 3'b010;
    nedge(2);
    check("R10 irq on", 32'(irq_out), 32'h1);
    // R9 clear channel 0
    irq_clr = 3'b001;
    nedge(1);
    irq_clr = 3'b000;
    nedge(1);
    check("R9 flag clear", 32'(irq_flag), 32'h6);
    irq_mask = 3'b001;
    nedge(2);
    check("R10 irq masked", 32'(irq_out), 32'h0);
    irq_mask = 3'b000;

    // R6 pops on channel 0 (holds 3333, 5555)
    pop_one(0);
    check("R6 head after pop", 32'(rd_data[TW-1:0]), 32'h5555);
    check("R6 count after pop", 32'(cnt_of(0)), 32'h1);
    pop_one(0);
    check("R6 count empty", 32'(cnt_of(0)), 32'h0);
    pop_one(0);
    check("R6 pop on empty", 32'(cnt_of(0)), 32'h0);

    // R5 glitch rejection and latency on channel 0 (rising mode)
    cap_pin[0] = 1'b0;
    nedge(6);
    check("R5 falling ignored", 32'(cnt_of(0)), 32'h0);
    timer_val = 16'h7777;
    cap_pin[0] = 1'b1;
    nedge(1);
    cap_pin[0] = 1'b0;
    nedge(6);
    check("R5 one-cycle pulse", 32'(cnt_of(0)), 32'h0);
    cap_pin[0] = 1'b1;
    nedge(3);
    check("R5 before third edge", 32'(cnt_of(0)), 32'h0);
    nedge(1);
    check("R5 at third edge", 32'(cnt_of(0)), 32'h1);
    check("R5 timestamp", 32'(rd_data[TW-1:0]), 32'h7777);

    // R8 status writes
    stat_write(6'b111111);
    check("R8 clamp", 32'(fifo_stat), 32'h2A00);
    stat_write(6'b000100);
    check("R8 load", 32'(fifo_stat), 32'h0400);
    stat_write(6'b000000);
    check("R8 flush", 32'(fifo_stat), 32'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule